// File: doc/BRIEF.md
# Modem Handshake Control and Status Unit

This unit is the modem-handshake slice of a serial port. A CPU writes a small control register whose low four bits drive four active-low handshake outputs. Bit 4 of that register selects a diagnostic loopback mode. The CPU reads a status register. Its upper nibble shows the present state of four handshake inputs, and its lower nibble holds change flags that are cleared when the register is read. Whenever the modem-status interrupt enable is on and any change flag is set, the unit raises an interrupt request.

In loopback mode the unit redirects signals inside itself. The transmit shift output goes straight to the receive shift input, and the serial output pin rests at mark. The four handshake output pins go inactive. The status logic then watches the control register's own bits in place of the external inputs. This lets software test both the data path and the handshake path without a cable. The external inputs are brought into the clock domain through a two-flop synchronizer before any change is detected.

Top module: `modem_ctl_unit`

## Requirements
- R1: Control bits 0, 1, 2 and 3 drive `dtr_out_n`, `rts_out_n`, `aux1_out_n` and `aux2_out_n`. A 1 drives the pin low and a 0 drives it high. After reset all four pins are high.
- R2: A write with `reg_addr`=0 stores `reg_wdata[4:0]`. A read with `reg_addr`=0 returns them with bits 7..5 always 0. `reg_rdata` is valid on the clock edge after the one that sampled `reg_rd`.
- R3: When control bit 4 is 0, `ser_out` follows `tx_bit` and `rx_bit` follows `ser_in`. When bit 4 is 1, `ser_out` is 1, `rx_bit` follows `tx_bit`, and `ser_in` is ignored.
- R4: In loopback all four handshake output pins are high, whatever control bits 0..3 hold.
- R5: In loopback the status bits take their values from control bits and the external handshake inputs are ignored. Status bit 4 (CTS) takes control bit 1, bit 5 (DSR) takes bit 0, bit 6 (RI) takes bit 2, and bit 7 (DCD) takes bit 3.
- R6: Outside loopback, status bits 4 (CTS), 5 (DSR), 6 (RI) and 7 (DCD) are the inverse of `cts_in_n`, `dsr_in_n`, `ri_in_n` and `dcd_in_n`, taken after a two-flop synchronizer.
- R7: Status bits 0 (CTS change), 1 (DSR change) and 3 (DCD change) set when the matching status bit changes in either direction.
- R8: Status bit 2 sets only when the ring input pin goes from low to high, which in loopback means control bit 2 going from 1 to 0. The opposite transition leaves it clear.
- R9: A read with `reg_addr`=1 returns the status byte and then clears bits 0..3. A change detected in the same cycle as that read keeps its flag set.
- R10: `msi_req` is high exactly when `msi_enable` is 1 and any of status bits 0..3 is set. This applies in loopback as well.
- R11: Reset clears the control register and all change flags. Input levels held steady across reset produce no change flag afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| cts_in_n | input | 1 | Clear-to-send input, active low |
| dsr_in_n | input | 1 | Data-set-ready input, active low |
| ri_in_n | input | 1 | Ring input, active low |
| dcd_in_n | input | 1 | Carrier-detect input, active low |
| dtr_out_n | output | 1 | Terminal-ready output, active low |
| rts_out_n | output | 1 | Request-to-send output, active low |
| aux1_out_n | output | 1 | User output 1, active low |
| aux2_out_n | output | 1 | User output 2, active low |
| ser_in | input | 1 | External serial line input |
| ser_out | output | 1 | External serial line output |
| tx_bit | input | 1 | Transmit shift register output |
| rx_bit | output | 1 | Receive shift register input |
| msi_enable | input | 1 | Modem-status interrupt enable |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
The change-detection logic is driven by single-pin falls and rises on each handshake input. This separates the both-edge flags from the ring flag, which must react to only one polarity. In loopback, a walking one is written through control bits 0..3. Each step moves one status bit up and the previous one down, which exposes any swapped mapping or a missed flag on the falling side. A change that lands in the same cycle as a status read checks the set-over-clear rule. Inputs held active across reset check that reset raises no false flag.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
  localparam int LINES  = 4;
  localparam int CTRL_W = 5;
  localparam int DATA_W = 8;

  // line positions, shared by status bits [3:0] and [7:4]
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  // control register fields
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_AUX1 = 2;
  localparam int C_AUX2 = 3;
  localparam int C_LOOP = 4;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_STAT = 1'b1} reg_sel_e;

  // internal handshake mapping used in loopback
  function automatic logic [LINES-1:0] loop_map(input logic [CTRL_W-1:0] c);
    logic [LINES-1:0] m;
    m[L_CTS] = c[C_RTS];
    m[L_DSR] = c[C_DTR];
    m[L_RI]  = c[C_AUX1];
    m[L_DCD] = c[C_AUX2];
    return m;
  endfunction
endpackage

// File: rtl/mcu_sync.sv
module mcu_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) stage[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/mcu_ctrl.sv
module mcu_ctrl
  import mcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [LINES-1:0]  pins_n
);
  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= '0;
    else if (wr_hit) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  always_comb begin
    if (ctrl_q[C_LOOP]) pins_n = '1;
    else                pins_n = ~ctrl_q[LINES-1:0];
  end

  // R2: upper write bits are dropped, low bits are stored
  a_r2_store_low: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && (|wr_data[DATA_W-1:CTRL_W])) |=> ctrl_q == $past(wr_data[CTRL_W-1:0]));
endmodule

// File: rtl/mcu_status.sv
module mcu_status
  import mcu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] cur,
  input  logic             rd_clr,
  input  logic             irq_en,
  output logic [LINES-1:0] delta_q,
  output logic             irq
);
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] evt;

  for (genvar i = 0; i < LINES; i++) begin : g_evt
    if (i == L_RI) begin : g_ring
      // status bit falling = ring pin rising
      assign evt[i] = prev_q[i] & ~cur[i];
    end else begin : g_both
      assign evt[i] = prev_q[i] ^ cur[i];
    end
  end

  always_ff @(posedge clk) begin
    prev_q <= cur;
    if (rst) delta_q <= '0;
    else     delta_q <= (delta_q & ~{LINES{rd_clr}}) | evt;
  end

  assign irq = irq_en & (|delta_q);

  // R7: a detected change always leaves its flag set
  a_r7_flag_sets: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((delta_q & $past(evt)) == $past(evt)));
  // R8: ring status rising (pin falling) never raises the ring flag
  a_r8_ring_one_edge: assert property (@(posedge clk) disable iff (rst)
    (!prev_q[L_RI] && cur[L_RI] && !delta_q[L_RI]) |=> !delta_q[L_RI]);
  // R9: a read clears every flag that saw no new change
  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> ((delta_q & ~$past(evt)) == '0));
  // R11: no flag is left standing by reset
  a_r11_reset_clean: assert property (@(posedge clk)
    $fell(rst) |-> delta_q == '0);
endmodule

// File: rtl/modem_ctl_unit.sv
module modem_ctl_unit
  import mcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cts_in_n,
  input  logic              dsr_in_n,
  input  logic              ri_in_n,
  input  logic              dcd_in_n,
  output logic              dtr_out_n,
  output logic              rts_out_n,
  output logic              aux1_out_n,
  output logic              aux2_out_n,
  input  logic              ser_in,
  output logic              ser_out,
  input  logic              tx_bit,
  output logic              rx_bit,
  input  logic              msi_enable,
  output logic              msi_req
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [LINES-1:0]  pins_n;
  logic [LINES-1:0]  ext_n;
  logic [LINES-1:0]  ext_sync_n;
  logic [LINES-1:0]  cur;
  logic [LINES-1:0]  delta_q;
  logic              loop_on;
  logic              wr_hit;
  logic              rd_stat;

  assign wr_hit  = reg_wr && (reg_addr == SEL_CTRL);
  assign rd_stat = reg_rd && (reg_addr == SEL_STAT);
  assign loop_on = ctrl_q[C_LOOP];

  always_comb begin
    ext_n        = '0;
    ext_n[L_CTS] = cts_in_n;
    ext_n[L_DSR] = dsr_in_n;
    ext_n[L_RI]  = ri_in_n;
    ext_n[L_DCD] = dcd_in_n;
  end

  mcu_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_hit  (wr_hit),
    .wr_data (reg_wdata),
    .ctrl_q  (ctrl_q),
    .pins_n  (pins_n)
  );

  mcu_sync #(.W(LINES), .STAGES(2)) u_sync (
    .clk (clk),
    .d   (ext_n),
    .q   (ext_sync_n)
  );

  assign cur = loop_on ? loop_map(ctrl_q) : ~ext_sync_n;

  mcu_status u_status (
    .clk     (clk),
    .rst     (rst),
    .cur     (cur),
    .rd_clr  (rd_stat),
    .irq_en  (msi_enable),
    .delta_q (delta_q),
    .irq     (msi_req)
  );

  assign dtr_out_n  = pins_n[C_DTR];
  assign rts_out_n  = pins_n[C_RTS];
  assign aux1_out_n = pins_n[C_AUX1];
  assign aux2_out_n = pins_n[C_AUX2];

  assign ser_out = loop_on ? 1'b1   : tx_bit;
  assign rx_bit  = loop_on ? tx_bit : ser_in;

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      if (reg_addr == SEL_STAT) reg_rdata <= {cur, delta_q};
      else                      reg_rdata <= {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
    end
  end

  // R2: control readback has zero upper bits
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == SEL_CTRL) |=> reg_rdata[DATA_W-1:CTRL_W] == '0);
  // R3: serial output rests at mark in loopback
  a_r3_sout_mark: assert property (@(posedge clk) disable iff (rst)
    loop_on |-> ser_out);
  // R4: handshake pins inactive in loopback
  a_r4_pins_idle: assert property (@(posedge clk) disable iff (rst)
    loop_on |-> (dtr_out_n && rts_out_n && aux1_out_n && aux2_out_n));
  // R10: request needs the enable and a flag
  a_r10_irq_gate: assert property (@(posedge clk) disable iff (rst)
    msi_req |-> (msi_enable && (|reg_status_low())));

  function automatic logic [LINES-1:0] reg_status_low();
    return delta_q;
  endfunction
endmodule

// File: tb/modem_ctl_unit_test.sv
`timescale 1ns/1ps
module modem_ctl_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic dtr_o, rts_o, aux1_o, aux2_o;
  logic ser_in = 1'b0, tx_bit = 1'b0, msi_enable = 1'b0;
  logic ser_out, rx_bit, msi_req;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  modem_ctl_unit uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cts_in_n(cts_n), .dsr_in_n(dsr_n), .ri_in_n(ri_n), .dcd_in_n(dcd_n),
    .dtr_out_n(dtr_o), .rts_out_n(rts_o), .aux1_out_n(aux1_o), .aux2_out_n(aux2_o),
    .ser_in(ser_in), .ser_out(ser_out), .tx_bit(tx_bit), .rx_bit(rx_bit),
    .msi_enable(msi_enable), .msi_req(msi_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    reg_addr = 1'b0; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [7:0] pins();
    return {4'h0, aux2_o, aux1_o, rts_o, dtr_o};
  endfunction

  task automatic do_reset();
    rst = 1'b1; idle(4); rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    check("R1 reset pins high", pins(), 8'h0F);
    rd(1'b0, d); check("R11 ctrl after reset", d, 8'h00);
    rd(1'b1, d); check("R11 status after reset", d, 8'h00);
    check("R10 no request after reset", {7'd0, msi_req}, 8'h00);
    cts_n = 1'b0; dcd_n = 1'b0;
    do_reset();
    rd(1'b1, d); check("R11 active inputs no false flag", d, 8'h90);
    cts_n = 1'b1; dcd_n = 1'b1; idle(3);
    rd(1'b1, d); check("R7 rise flags CTS DCD", d, 8'h09);
    rd(1'b1, d); check("R9 flags cleared", d, 8'h00);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr_ctrl(8'h05);
    check("R1 pins for 0x05", pins(), 8'h0A);
    rd(1'b0, d); check("R2 readback 0x05", d, 8'h05);
    wr_ctrl(8'hEA);
    check("R1 pins for 0x0A", pins(), 8'h05);
    rd(1'b0, d); check("R2 upper bits read zero", d, 8'h0A);
    wr_ctrl(8'h00);
  endtask

  task automatic t_serial();
    tx_bit = 1'b0; ser_in = 1'b1; #1;
    check("R3 normal sout", {7'd0, ser_out}, 8'h00);
    check("R3 normal rx high", {7'd0, rx_bit}, 8'h01);
    ser_in = 1'b0; tx_bit = 1'b1; #1;
    check("R3 normal rx low", {7'd0, rx_bit}, 8'h00);
    check("R3 normal sout high", {7'd0, ser_out}, 8'h01);
    idle(1);
    wr_ctrl(8'h10);
    tx_bit = 1'b0; ser_in = 1'b1; #1;
    check("R3 loop sout mark", {7'd0, ser_out}, 8'h01);
    check("R3 loop rx from tx 0", {7'd0, rx_bit}, 8'h00);
    tx_bit = 1'b1; ser_in = 1'b0; #1;
    check("R3 loop rx from tx 1", {7'd0, rx_bit}, 8'h01);
    idle(1);
    wr_ctrl(8'h00);
    tx_bit = 1'b0; ser_in = 1'b0;
  endtask

  task automatic t_delta();
    logic [7:0] d;
    idle(1);
    cts_n = 1'b0; idle(3);
    rd(1'b1, d); check("R7 CTS fall flag", d, 8'h11);
    rd(1'b1, d); check("R9 CTS flag cleared", d, 8'h10);
    cts_n = 1'b1; idle(3);
    rd(1'b1, d); check("R7 CTS rise flag", d, 8'h01);
    dsr_n = 1'b0; idle(3);
    rd(1'b1, d); check("R6 R7 DSR fall", d, 8'h22);
    dsr_n = 1'b1; idle(3);
    rd(1'b1, d); check("R7 DSR rise", d, 8'h02);
    dcd_n = 1'b0; idle(3);
    rd(1'b1, d); check("R6 R7 DCD fall", d, 8'h88);
    dcd_n = 1'b1; idle(3);
    rd(1'b1, d); check("R7 DCD rise", d, 8'h08);
  endtask

  task automatic t_ring();
    logic [7:0] d;
    ri_n = 1'b0; idle(3);
    rd(1'b1, d); check("R8 ring pin fall no flag", d, 8'h40);
    ri_n = 1'b1; idle(3);
    rd(1'b1, d); check("R8 ring pin rise flag", d, 8'h04);
    rd(1'b1, d); check("R9 ring flag cleared", d, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    cts_n = 1'b0; idle(2);
    rd(1'b1, d); check("R9 read during change", d, 8'h10);
    rd(1'b1, d); check("R9 change kept over clear", d, 8'h11);
    cts_n = 1'b1; idle(3);
    rd(1'b1, d); check("R7 restore", d, 8'h01);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    msi_enable = 1'b1;
    dsr_n = 1'b0; idle(3);
    check("R10 request raised", {7'd0, msi_req}, 8'h01);
    msi_enable = 1'b0; #1;
    check("R10 request gated", {7'd0, msi_req}, 8'h00);
    msi_enable = 1'b1; #1;
    rd(1'b1, d); check("R10 status for DSR", d, 8'h22);
    check("R10 request drops after read", {7'd0, msi_req}, 8'h00);
    dsr_n = 1'b1; idle(3);
    rd(1'b1, d); check("R7 DSR back", d, 8'h02);
    msi_enable = 1'b0;
  endtask

  task automatic t_loop();
    logic [7:0] d;
    wr_ctrl(8'h10); idle(1);
    rd(1'b1, d); check("R5 loop entry quiet", d, 8'h00);
    cts_n = 1'b0; idle(3);
    rd(1'b1, d); check("R5 external input ignored", d, 8'h00);
    msi_enable = 1'b1;
    wr_ctrl(8'h11); idle(1);
    check("R4 pins idle with DTR set", pins(), 8'h0F);
    rd(1'b1, d); check("R5 DTR to DSR", d, 8'h22);
    wr_ctrl(8'h12); idle(1);
    rd(1'b1, d); check("R5 RTS to CTS", d, 8'h13);
    wr_ctrl(8'h14); idle(1);
    rd(1'b1, d); check("R5 R8 AUX1 to RI no flag", d, 8'h41);
    wr_ctrl(8'h18); idle(1);
    check("R10 request in loopback", {7'd0, msi_req}, 8'h01);
    rd(1'b1, d); check("R5 R8 AUX2 to DCD and ring flag", d, 8'h8C);
    wr_ctrl(8'h1F);
    check("R4 pins idle all set", pins(), 8'h0F);
    rd(1'b0, d); check("R2 loop readback", d, 8'h1F);
    msi_enable = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_serial();
    t_delta();
    t_ring();
    t_collide();
    t_irq();
    t_loop();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule